// File: doc/BRIEF.md
# Pulse Accumulator Counter

This block counts activity on a single external pin with a 16-bit counter. It has two modes. In edge mode the counter advances once for each chosen transition of the pin. In gated mode the counter advances once for every 64 system clocks for as long as the pin stays at its active level, which measures the pin's active time. The pin is synchronised to the system clock before any edge or level is examined. A free-running divide-by-64 prescaler produces a one-cycle count enable.

Two sticky flags record events. The edge flag sets on each chosen edge in edge mode, and on the end of the active level in gated mode. The wrap flag sets when the count rolls over from all ones to zero. Each flag drives its own interrupt line, and each line has its own enable. Software writes a 2-bit address and an 8-bit data byte to reach the control byte, the flag byte (write one to clear), and the two halves of the count. A typical use is to preset the count to the two's complement of N, so that the wrap interrupt fires after N events.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset the count is 0x0000, both flags are 0 and both interrupt outputs are 0.
- R2: While control bit 0 (enable) is 0, pin activity changes neither the count nor either flag.
- R3: With enable set and control bit 1 (mode) at 0, the count rises by one for each synchronised pin edge of the kind chosen by control bit 2: rising when 1, falling when 0.
- R4: With enable set and mode at 1, the count rises by one on each divide-by-64 tick while the synchronised pin is at its active level. The active level is high when control bit 2 is 1 and low when it is 0.
- R5: Flag bit 1 (wrap) sets when an increment takes the count from 0xFFFF to 0x0000.
- R6: Flag bit 0 (edge) sets on each chosen edge in edge mode. In gated mode it sets only when the pin leaves its active level, not when it enters it.
- R7: Writing to address 1 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R8: irq_ovf_o is the wrap flag gated by control bit 3, and irq_edge_o is the edge flag gated by control bit 4.
- R9: Address 2 writes the high byte of the count and address 3 writes the low byte. The other byte is left unchanged. Address 0 writes the control byte.
- R10: A count byte write made in the same cycle as an increment takes effect, and that increment is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous pulse input |
| wr_valid_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 2 | Register select: 0 control, 1 flags, 2 count high, 3 count low |
| wr_data_i | input | 8 | Write data |
| count_o | output | 16 | Current count |
| edge_flag_o | output | 1 | Edge flag |
| ovf_flag_o | output | 1 | Wrap flag |
| irq_edge_o | output | 1 | Edge interrupt request |
| irq_ovf_o | output | 1 | Wrap interrupt request |

## Verification
The properties assume that the count moves by at most one per cycle whenever no count byte is written. They also assume that a disabled block, or a gated block between ticks, leaves the count alone. For these to hold, each count write must be a single-byte strobe. The stimulus holds every pin level for at least two clocks, so that no edge is lost in the synchroniser. It also changes the pin in gated tests only at a fixed phase well away from a prescaler tick, so that the expected tick count is exact.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_FLAG   = 2'd1,
        ADDR_CNT_HI = 2'd2,
        ADDR_CNT_LO = 2'd3
    } pacc_addr_e;

    // control byte, bit 0 at the right
    typedef struct packed {
        logic edge_ie;   // bit 4
        logic ovf_ie;    // bit 3
        logic pol;       // bit 2: 1 rising / active high
        logic gated;     // bit 1: 1 gated duration mode
        logic enable;    // bit 0
    } pacc_ctrl_t;

    localparam int CTRL_W   = 5;
    localparam int FLAG_EDGE = 0;
    localparam int FLAG_OVF  = 1;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_N-2:0], async_i};
        st_d.prev  = st_q.chain[SYNC_N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[SYNC_N-1];
    assign rise_o  = level_o & ~st_q.prev;
    assign fall_o  = ~level_o & st_q.prev;
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] div_d, div_q;

    always_comb div_d = div_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // high for one cycle in every 2**DIV_LOG2
    assign tick_o = &div_q;
endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              gated_i,
    input  logic              pol_i,
    input  logic              level_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              tick_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [1:0]        flag_clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              edge_flag_o,
    output logic              ovf_flag_o
);
    import pacc_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             edge_f;
        logic             ovf_f;
    } core_st_t;

    core_st_t st_d, st_q;

    logic chosen_edge, active, trailing, bump, wrap, edge_set;

    always_comb begin
        chosen_edge = pol_i ? rise_i : fall_i;
        active      = pol_i ? level_i : ~level_i;
        trailing    = pol_i ? fall_i : rise_i;
        bump        = en_i & (gated_i ? (tick_i & active) : chosen_edge);
        edge_set    = en_i & (gated_i ? trailing : chosen_edge);
        wrap        = 1'b0;
        st_d        = st_q;

        if (wr_hi_i || wr_lo_i) begin
            // a byte write wins over an increment in the same cycle
            if (wr_hi_i) st_d.cnt[CNT_W-1:BYTE_W] = wr_byte_i;
            if (wr_lo_i) st_d.cnt[BYTE_W-1:0]     = wr_byte_i;
        end else if (bump) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end

        // a set in the same cycle as a clear wins
        st_d.edge_f = (st_q.edge_f & ~flag_clr_i[FLAG_EDGE]) | edge_set;
        st_d.ovf_f  = (st_q.ovf_f  & ~flag_clr_i[FLAG_OVF])  | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o     = st_q.cnt;
    assign edge_flag_o = st_q.edge_f;
    assign ovf_flag_o  = st_q.ovf_f;
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top #(
    parameter int BYTE_W   = 8,
    parameter int DIV_LOG2 = 6,
    parameter int SYNC_N   = 2,
    localparam int CNT_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              wr_valid_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              edge_flag_o,
    output logic              ovf_flag_o,
    output logic              irq_edge_o,
    output logic              irq_ovf_o
);
    import pacc_pkg::*;

    pacc_ctrl_t ctrl_d, ctrl_q;
    logic       lvl, rise, fall, tick;
    logic       wr_hi, wr_lo;
    logic [1:0] flag_clr;
    logic       en_w, gated_w, cnt_wr;

    always_comb begin
        ctrl_d   = ctrl_q;
        wr_hi    = 1'b0;
        wr_lo    = 1'b0;
        flag_clr = '0;
        if (wr_valid_i) begin
            unique case (pacc_addr_e'(wr_addr_i))
                ADDR_CTRL:   ctrl_d   = pacc_ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ADDR_FLAG:   flag_clr = wr_data_i[1:0];
                ADDR_CNT_HI: wr_hi    = 1'b1;
                ADDR_CNT_LO: wr_lo    = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign en_w    = ctrl_q.enable;
    assign gated_w = ctrl_q.gated;
    assign cnt_wr  = wr_hi | wr_lo;

    pacc_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    pacc_prescale #(.DIV_LOG2(DIV_LOG2)) u_psc (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pacc_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .en_i(ctrl_q.enable), .gated_i(ctrl_q.gated), .pol_i(ctrl_q.pol),
        .level_i(lvl), .rise_i(rise), .fall_i(fall), .tick_i(tick),
        .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_byte_i(wr_data_i),
        .flag_clr_i(flag_clr),
        .count_o(count_o), .edge_flag_o(edge_flag_o), .ovf_flag_o(ovf_flag_o)
    );

    assign irq_edge_o = edge_flag_o & ctrl_q.edge_ie;
    assign irq_ovf_o  = ovf_flag_o  & ctrl_q.ovf_ie;
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             gated,
    input logic             tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] count,
    input logic             edge_flag,
    input logic             ovf_flag
);
    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count));

    // R2
    disabled_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!$rose(edge_flag) && !$rose(ovf_flag)));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R4
    gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gated && !tick && !cnt_wr) |=> $stable(count));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0));
endmodule

bind pulse_acc_top pacc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .gated(gated_w), .tick(tick),
    .cnt_wr(cnt_wr), .count(count_o), .edge_flag(edge_flag_o), .ovf_flag(ovf_flag_o)
);

// File: tb/sim_pulse_acc_top.sv
`timescale 1ns/1ps
module sim_pulse_acc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [15:0] count_o;
    logic        edge_flag_o, ovf_flag_o, irq_edge_o, irq_ovf_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    pulse_acc_top u0 (.*);

    function automatic logic [7:0] mkctrl(input logic en, input logic gated,
                                          input logic pol, input logic oie, input logic eie);
        return {3'b000, eie, oie, pol, gated, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic drive(input logic v, input int hold);
        @(negedge clk);
        pin_in = v;
        repeat (hold) @(posedge clk);
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic align();
        do @(negedge clk); while ((cyc % 64) != 10);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] exp_cnt;
        logic        pol;
        logic        lvl;
        int          hits;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 count", count_o, 0);
        chk("R1 flags", {edge_flag_o, ovf_flag_o}, 0);
        chk("R1 irqs", {irq_edge_o, irq_ovf_o}, 0);

        // R2: disabled, pin toggles do nothing
        for (int i = 0; i < 6; i++) drive(~pin_in, 3);
        drive(1'b0, 3);
        settle();
        chk("R2 count held", count_o, 0);
        chk("R2 flags held", {edge_flag_o, ovf_flag_o}, 0);

        // R9: byte writes
        wr(2'd2, 8'hA5);
        chk("R9 high byte", count_o, 16'hA500);
        wr(2'd3, 8'h3C);
        chk("R9 low byte", count_o, 16'hA53C);

        // R3: random edges in edge mode, both polarities
        for (int pass = 0; pass < 4; pass++) begin
            pol = pass[0];
            drive(~pol, 3);
            wr(2'd0, mkctrl(1'b1, 1'b0, pol, 1'b0, 1'b0));
            wr(2'd2, 8'h00);
            wr(2'd3, 8'h00);
            wr(2'd1, 8'h03);
            exp_cnt = 0;
            hits = 0;
            lvl = ~pol;
            for (int i = 0; i < 30; i++) begin
                lvl = ~lvl;
                drive(lvl, 2 + int'($urandom_range(7)));
                if (lvl == pol) begin exp_cnt++; hits++; end
            end
            settle();
            chk(pol ? "R3 rising count" : "R3 falling count", count_o, exp_cnt);
            chk("R6 edge flag edge mode", edge_flag_o, hits > 0);
        end

        // R10: write in the same cycle as an increment
        drive(1'b0, 3);
        wr(2'd0, mkctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        wr(2'd2, 8'h12);
        wr(2'd3, 8'h34);
        @(negedge clk); pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_valid_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 8'h55;
        @(negedge clk); wr_valid_i = 1'b0;
        settle();
        chk("R10 write beats increment", count_o, 16'h1255);

        // R5, R8: wrap
        drive(1'b0, 3);
        wr(2'd0, mkctrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
        wr(2'd1, 8'h03);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFE);
        drive(1'b1, 3); drive(1'b0, 3);
        settle();
        chk("R5 before wrap", {count_o, ovf_flag_o}, {16'hFFFF, 1'b0});
        drive(1'b1, 3); drive(1'b0, 3);
        settle();
        chk("R5 count wrapped", count_o, 0);
        chk("R5 wrap flag", ovf_flag_o, 1);
        chk("R8 irq lines enabled", {irq_edge_o, irq_ovf_o}, 2'b11);
        wr(2'd0, mkctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R8 irq lines masked", {irq_edge_o, irq_ovf_o}, 2'b00);

        // R7: write-one-to-clear
        wr(2'd1, 8'h00);
        chk("R7 zero write keeps", {edge_flag_o, ovf_flag_o}, 2'b11);
        wr(2'd1, 8'h02);
        chk("R7 clear wrap only", {edge_flag_o, ovf_flag_o}, 2'b10);
        wr(2'd1, 8'h01);
        chk("R7 clear edge", {edge_flag_o, ovf_flag_o}, 2'b00);

        // R4, R6: gated mode, active high then active low
        for (int pass = 0; pass < 2; pass++) begin
            int m;
            pol = (pass == 0);
            m = 2 + pass;
            drive(~pol, 3);
            wr(2'd0, mkctrl(1'b1, 1'b1, pol, 1'b0, 1'b0));
            wr(2'd2, 8'h00);
            wr(2'd3, 8'h00);
            wr(2'd1, 8'h03);
            align();
            pin_in = pol;
            repeat (32) @(posedge clk);
            @(negedge clk);
            chk("R6 no flag on leading edge", edge_flag_o, 0);
            repeat (m * 64 - 33) @(posedge clk);
            @(negedge clk);
            pin_in = ~pol;
            settle();
            chk(pol ? "R4 gated high count" : "R4 gated low count", count_o, m);
            chk("R6 flag on trailing edge", edge_flag_o, 1);
        end

        finish_run();
    end
endmodule